// File: doc/BRIEF.md
# In-System Programming Serial Sequencer

This block lives on the programmer side of an in-system programming link and drives a target microcontroller's serial programming port. It supplies three target-facing signals: a reset line, a serial clock and a data line toward the target. It reads one data line coming back from the target. After its own reset it brings the target into programming mode on its own. It holds the target reset and the serial clock low, then raises the reset line for a short pulse. It waits a settle time and then shifts out a fixed four-byte programming-enable word.

The target echoes bytes back during that word. If the echo that should repeat the enable word's second byte comes back wrong, the block flags loss of sync and runs the whole entry sequence again with a fresh reset pulse. Once entry succeeds, a host hands over one 32-bit instruction at a time with a start pulse. The block shifts the instruction out most significant bit first, captures the 32 bits returned by the target, and reports them with a one-cycle done pulse.

The serial clock's high and low phases are whole numbers of system clocks. They are derived at elaboration from the system and target clock frequencies. The minimum number of target CPU cycles per phase rises from two to three once the target clock reaches 12 MHz.

Top module: `isp_spi_sequencer`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, tgt_rst_o, sck_o, mosi_o and done_o are 0 and busy_o is 1.
- R2: After reset, tgt_rst_o stays low with sck_o low for PULSE_CYC cycles. It is then high for exactly PULSE_CYC = ceil(2*SYS_KHZ/TGT_KHZ) cycles. sck_o is never high while tgt_rst_o is high.
- R3: The first rising edge of sck_o after tgt_rst_o falls comes exactly SETTLE_CYC + HALF_CYC cycles later, with SETTLE_CYC = SETTLE_US*SYS_KHZ/1000.
- R4: The first word shifted out after each reset pulse is ENABLE_WORD (default 0xAC53_0000).
- R5: Every high phase of sck_o lasts HALF_CYC cycles, and so does every low phase between two bits of one word. HALF_CYC = floor(M*SYS_KHZ/TGT_KHZ)+1, where M = 3 when TGT_KHZ >= 12000 and M = 2 otherwise.
- R6: mosi_o changes only together with a falling edge of sck_o or at the start of a word. It is stable through each rising edge and high phase. Bits go out MSB first, so cmd_i[31:24] is the first byte.
- R7: miso_i is sampled in the last system clock of each low phase. When done_o is high, rdata_o holds the 32 samples, the first in bit 31.
- R8: If bits [15:8] of the word returned during the enable word differ from ENABLE_WORD[23:16], out_of_sync_o goes high and the sequence restarts at R2. A matching echo clears it. out_of_sync_o is never high while busy_o is low.
- R9: busy_o is high from reset until an enable word is accepted. A start_i pulse while busy_o is high is ignored: it sends no word and produces no done_o.
- R10: A start_i pulse while busy_o is low shifts out cmd_i. done_o is high for one cycle after the last falling edge of sck_o, and busy_o is low on the cycle after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Host start pulse for one instruction |
| cmd_i | input | 32 | Instruction to send, first byte in [31:24] |
| done_o | output | 1 | One-cycle pulse when an instruction finishes |
| rdata_o | output | 32 | Bits returned by the target, first in [31] |
| busy_o | output | 1 | High while entry or an instruction is in progress |
| out_of_sync_o | output | 1 | Enable echo mismatch seen, entry being retried |
| tgt_rst_o | output | 1 | Target reset line |
| sck_o | output | 1 | Serial clock to target |
| mosi_o | output | 1 | Serial data to target |
| miso_i | input | 1 | Serial data from target |

## Verification
The bench builds two instances with SYS_KHZ = 200000 and SETTLE_US = 1. One uses TGT_KHZ = 16000 (HALF_CYC 38, PULSE_CYC 25) and the other TGT_KHZ = 8000 (HALF_CYC 51, PULSE_CYC 50), so both sides of the 12 MHz threshold are measured in one run. The one-microsecond settle shrinks the wait to 200 cycles. That leaves room for the slower instance's target model to corrupt the enable echo twice, forcing two full re-entry sequences before host traffic.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_PULSE,
    ST_SETTLE,
    ST_ENTER,
    ST_IDLE,
    ST_XFER
  } isp_state_e;
endpackage

// File: rtl/isp_phase_timer.sv
module isp_phase_timer #(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(HALF_CYC));
endmodule

// File: rtl/isp_shift_engine.sv
module isp_shift_engine #(
  parameter int unsigned HALF_CYC = 4,
  parameter int unsigned W        = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] tx_i,
  input  logic         miso_i,
  output logic         sck_o,
  output logic         mosi_o,
  output logic [W-1:0] rx_o,
  output logic         fin_o
);
  localparam int unsigned BW = $clog2(W);

  logic          active_q, sck_q, fin_q, tick;
  logic [BW-1:0] bit_q;
  logic [W-1:0]  tx_q, rx_q;

  isp_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (active_q),
    .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      fin_q    <= 1'b0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go_i && !active_q) begin
        active_q <= 1'b1;
        tx_q     <= tx_i;
        bit_q    <= '0;
        sck_q    <= 1'b0;
      end else if (tick) begin
        if (!sck_q) begin
          // sample on the last low cycle, then raise
          rx_q  <= {rx_q[W-2:0], miso_i};
          sck_q <= 1'b1;
        end else begin
          sck_q <= 1'b0;
          tx_q  <= {tx_q[W-2:0], 1'b0};
          if (bit_q == BW'(W - 1)) begin
            active_q <= 1'b0;
            fin_q    <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = active_q & tx_q[W-1];
  assign rx_o   = rx_q;
  assign fin_o  = fin_q;

  assert_mosi_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(mosi_o));
  assert_go_when_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !active_q);
  assert_fin_low_sck_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> !sck_o);
endmodule

// File: rtl/isp_spi_sequencer.sv
module isp_spi_sequencer
  import isp_pkg::*;
#(
  parameter int unsigned    SYS_KHZ     = 200000,
  parameter int unsigned    TGT_KHZ     = 16000,
  parameter int unsigned    SETTLE_US   = 20000,
  parameter logic [31:0]    ENABLE_WORD = 32'hAC53_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] cmd_i,
  output logic        done_o,
  output logic [31:0] rdata_o,
  output logic        busy_o,
  output logic        out_of_sync_o,
  output logic        tgt_rst_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i
);
  localparam int unsigned     MIN_TGT   = (TGT_KHZ >= 12000) ? 3 : 2;
  localparam int unsigned     HALF_CYC  = (MIN_TGT * SYS_KHZ) / TGT_KHZ + 1;
  localparam longint unsigned PULSE_CYC = (64'(2) * SYS_KHZ + TGT_KHZ - 1) / TGT_KHZ;
  localparam longint unsigned SETTLE_RAW = (64'(SETTLE_US) * SYS_KHZ) / 1000;
  localparam longint unsigned SETTLE_CYC = (SETTLE_RAW > 0) ? SETTLE_RAW : 1;
  localparam longint unsigned DLY_MAX   = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int unsigned     DW        = $clog2(DLY_MAX + 1);

  isp_state_e      state_q;
  logic [DW-1:0]   dly_q, dly_lim;
  logic            dly_done, timed, go, fin, sync_ok, oos_q;
  logic [WORD_W-1:0] tx_word, rx_word;

  assign timed    = (state_q == ST_HOLD) || (state_q == ST_PULSE) || (state_q == ST_SETTLE);
  assign dly_lim  = (state_q == ST_SETTLE) ? DW'(SETTLE_CYC - 1) : DW'(PULSE_CYC - 1);
  assign dly_done = timed && (dly_q == dly_lim);
  assign go       = ((state_q == ST_SETTLE) && dly_done) || ((state_q == ST_IDLE) && start_i);
  assign tx_word  = (state_q == ST_IDLE) ? cmd_i : ENABLE_WORD;
  // target echoes byte 1 while byte 2 is shifting
  assign sync_ok  = rx_word[15:8] == ENABLE_WORD[23:16];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dly_q <= '0;
    else if (!timed || dly_done) dly_q <= '0;
    else               dly_q <= dly_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      oos_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_HOLD:   if (dly_done) state_q <= ST_PULSE;
        ST_PULSE:  if (dly_done) state_q <= ST_SETTLE;
        ST_SETTLE: if (dly_done) state_q <= ST_ENTER;
        ST_ENTER: if (fin) begin
          oos_q   <= !sync_ok;
          state_q <= sync_ok ? ST_IDLE : ST_HOLD;
        end
        ST_IDLE:   if (start_i) state_q <= ST_XFER;
        ST_XFER:   if (fin) state_q <= ST_IDLE;
        default:   state_q <= ST_HOLD;
      endcase
    end
  end

  isp_shift_engine #(.HALF_CYC(HALF_CYC), .W(WORD_W)) u_engine (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (go),
    .tx_i  (tx_word),
    .miso_i(miso_i),
    .sck_o (sck_o),
    .mosi_o(mosi_o),
    .rx_o  (rx_word),
    .fin_o (fin)
  );

  assign tgt_rst_o     = (state_q == ST_PULSE);
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_XFER) && fin;
  assign rdata_o       = rx_word;
  assign out_of_sync_o = oos_q;

  assert_rst_sck_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_rst_o |-> !sck_o);
  assert_oos_only_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !out_of_sync_o);
  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_idle_after_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  assert_rst_pulse_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tgt_rst_o) |-> !sck_o && !mosi_o);
endmodule

// File: tb/isp_spi_sequencer_tb.sv
`timescale 1ns/1ps

module isp_tb_target (
  input  logic        sck,
  input  logic        mosi,
  input  int          bad_n,
  output logic        miso,
  output logic [31:0] last_word,
  output int          n_words,
  output int          n_enable
);
  logic [31:0] rw;
  logic [7:0]  rb [4];
  logic [7:0]  r;
  int          bc;

  initial begin
    miso = 0; bc = 0; n_words = 0; n_enable = 0; last_word = 0; rw = 0;
    for (int i = 0; i < 4; i++) rb[i] = 0;
  end

  always @(posedge sck) begin
    rw = {rw[30:0], mosi};
    bc++;
    if (bc % 8 == 0) begin
      rb[bc/8-1] = rw[7:0];
      if (bc == 8 && rw[7:0] == 8'hAC) n_enable++;
    end
    if (bc == 32) begin
      last_word = rw; n_words++; bc = 0;
    end
  end

  always @(negedge sck) begin
    case (bc / 8)
      0: r = 8'h00;
      1: r = rb[0];
      2: r = rb[1] ^ ((rb[0] == 8'hAC && n_enable <= bad_n) ? 8'h01 : 8'h00);
      default: r = rb[2] ^ 8'hA5;
    endcase
    miso = (bc == 0) ? 1'b0 : r[7 - (bc % 8)];
  end
endmodule

module isp_tb_mon #(
  parameter int    HALF   = 1,
  parameter int    PULSE  = 1,
  parameter int    SETTLE = 1,
  parameter string TAG    = "x"
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic trst,
  output int   n_chk,
  output int   n_fail,
  output int   n_pulse
);
  int   ph, hi, since, rises;
  logic psck, pmosi, prst, await_r;

  initial begin
    n_chk = 0; n_fail = 0; n_pulse = 0; ph = 0; hi = 0; since = 0; rises = 0;
    psck = 0; pmosi = 0; prst = 0; await_r = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", TAG, req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (trst) begin
      hi++;
      if (sck) chk(0, "R2 sck high in reset pulse", 1, 0);
    end
    if (prst && !trst) begin
      chk(hi == PULSE, "R2 reset pulse length", hi, PULSE);
      hi = 0; n_pulse++; since = 1; await_r = 1;
    end else if (await_r && !sck && !trst) begin
      since++;
    end
    if (sck != psck) begin
      if (psck) chk(ph == HALF, "R5 high phase", ph, HALF);
      else begin
        chk(mosi == pmosi, "R6 mosi at rising edge", mosi, pmosi);
        if (rises % 32 != 0) chk(ph == HALF, "R5 low phase", ph, HALF);
        if (await_r) begin
          chk(since == SETTLE + HALF, "R3 settle to first edge", since, SETTLE + HALF);
          await_r = 0;
        end
        rises++;
      end
      ph = 1;
    end else begin
      ph++;
      if (sck && mosi != pmosi) chk(0, "R6 mosi moved while high", mosi, pmosi);
    end
    psck = sck; pmosi = mosi; prst = trst;
  end
endmodule

module isp_spi_sequencer_tb;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        start_a = 0, start_b = 0;
  logic [31:0] cmd_a = 0, cmd_b = 0;
  logic        done_a, busy_a, oos_a, trst_a, sck_a, mosi_a, miso_a;
  logic        done_b, busy_b, oos_b, trst_b, sck_b, mosi_b, miso_b;
  logic [31:0] rd_a, rd_b, lw_a, lw_b;
  int          nw_a, nw_b, ne_a, ne_b;
  int          mc_a, mf_a, mp_a, mc_b, mf_b, mp_b;
  int          n_chk = 0, n_fail = 0, dones_a = 0;
  bit          saw_oos_b = 0;

  isp_spi_sequencer #(.SYS_KHZ(200000), .TGT_KHZ(16000), .SETTLE_US(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .cmd_i(cmd_a), .done_o(done_a),
    .rdata_o(rd_a), .busy_o(busy_a), .out_of_sync_o(oos_a), .tgt_rst_o(trst_a),
    .sck_o(sck_a), .mosi_o(mosi_a), .miso_i(miso_a));

  isp_spi_sequencer #(.SYS_KHZ(200000), .TGT_KHZ(8000), .SETTLE_US(1)) u_dut_slow (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .cmd_i(cmd_b), .done_o(done_b),
    .rdata_o(rd_b), .busy_o(busy_b), .out_of_sync_o(oos_b), .tgt_rst_o(trst_b),
    .sck_o(sck_b), .mosi_o(mosi_b), .miso_i(miso_b));

  isp_tb_target u_tgt_a (.sck(sck_a), .mosi(mosi_a), .bad_n(0), .miso(miso_a),
    .last_word(lw_a), .n_words(nw_a), .n_enable(ne_a));
  isp_tb_target u_tgt_b (.sck(sck_b), .mosi(mosi_b), .bad_n(2), .miso(miso_b),
    .last_word(lw_b), .n_words(nw_b), .n_enable(ne_b));

  isp_tb_mon #(.HALF(38), .PULSE(25), .SETTLE(200), .TAG("fast")) u_mon_a (
    .clk(clk), .rst_n(rst_n), .sck(sck_a), .mosi(mosi_a), .trst(trst_a),
    .n_chk(mc_a), .n_fail(mf_a), .n_pulse(mp_a));
  isp_tb_mon #(.HALF(51), .PULSE(50), .SETTLE(200), .TAG("slow")) u_mon_b (
    .clk(clk), .rst_n(rst_n), .sck(sck_b), .mosi(mosi_b), .trst(trst_b),
    .n_chk(mc_b), .n_fail(mf_b), .n_pulse(mp_b));

  always @(negedge clk) begin
    if (oos_b) saw_oos_b = 1;
    if (done_a) dones_a++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk + mc_a + mc_b, n_fail + mf_a + mf_b);
    $finish;
  endtask

  function automatic logic [31:0] reply(input logic [31:0] c);
    return {8'h00, c[31:24], c[23:16], c[15:8] ^ 8'hA5};
  endfunction

  task automatic xfer_a(input logic [31:0] c);
    while (busy_a) @(negedge clk);
    start_a = 1; cmd_a = c;
    @(negedge clk);
    start_a = 0;
    while (!done_a) @(negedge clk);
    check(rd_a == reply(c), "R7 returned data", rd_a, reply(c));
    check(lw_a == c, "R6 word seen by target MSB first", lw_a, c);
    check(busy_a == 1, "R10 busy during done", 32'(busy_a), 1);
    @(negedge clk);
    check(done_a == 0 && busy_a == 0, "R10 single done then idle", {30'd0, done_a, busy_a}, 0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    check({trst_a, sck_a, mosi_a, done_a, busy_a} == 5'b00001, "R1 reset outputs (in reset)",
          {27'd0, trst_a, sck_a, mosi_a, done_a, busy_a}, 1);
    rst_n = 1;
    @(negedge clk);
    check({trst_a, sck_a, mosi_a, done_a, busy_a} == 5'b00001, "R1 outputs after reset",
          {27'd0, trst_a, sck_a, mosi_a, done_a, busy_a}, 1);
    check({trst_b, sck_b, busy_b} == 3'b001, "R1 slow outputs after reset",
          {29'd0, trst_b, sck_b, busy_b}, 1);

    // start during settle must be ignored (R9)
    while (!trst_a) @(negedge clk);
    while (trst_a) @(negedge clk);
    repeat (10) @(negedge clk);
    check(busy_a == 1, "R9 busy during settle", 32'(busy_a), 1);
    start_a = 1; cmd_a = 32'h5555_0000;
    @(negedge clk);
    start_a = 0;

    while (busy_a) @(negedge clk);
    check(nw_a == 1, "R9 only enable word sent", nw_a, 1);
    check(dones_a == 0, "R9 no done from ignored start", dones_a, 0);
    check(lw_a == 32'hAC53_0000, "R4 enable word", lw_a, 32'hAC53_0000);
    check(oos_a == 0, "R8 no sync loss on clean echo", 32'(oos_a), 0);
    check(mp_a == 1, "R2 single reset pulse", mp_a, 1);

    xfer_a(32'h1234_5678);
    xfer_a(32'hFFFF_FFFF);
    xfer_a(32'h0000_0000);
    xfer_a(32'h35C3_0F81);
    check(nw_a == 5, "R10 word count", nw_a, 5);

    while (busy_b) @(negedge clk);
    check(saw_oos_b == 1, "R8 sync loss flagged", 32'(saw_oos_b), 1);
    check(oos_b == 0, "R8 flag cleared on good echo", 32'(oos_b), 0);
    check(ne_b == 3, "R8 enable attempts", ne_b, 3);
    check(mp_b == 3, "R8 reset pulse per attempt", mp_b, 3);
    check(lw_b == 32'hAC53_0000, "R4 enable word after retry", lw_b, 32'hAC53_0000);

    start_b = 1; cmd_b = 32'h6B1E_22D0;
    @(negedge clk);
    start_b = 0;
    while (!done_b) @(negedge clk);
    check(rd_b == reply(32'h6B1E_22D0), "R7 slow returned data", rd_b, reply(32'h6B1E_22D0));
    @(negedge clk);
    check(busy_b == 0, "R10 slow idle after done", 32'(busy_b), 0);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule